// File: doc/BRIEF.md
# Vectored Interrupt Dispatch

This block sits beside a processor's exception unit. Each cycle it looks at the hardware interrupt lines that are pending, the mask or level field and the global interrupt status bits. It decides whether a hardware interrupt must be taken and, if so, at which offset from the exception base the handler starts. Both answers are registered, so they appear one clock after the inputs that produced them.

Three modes are supported:

- **Compatibility.** The mask field holds one enable per line. The offset is either the general exception entry or the special interrupt entry.
- **Internally vectored.** The mask field still holds per-line enables. The vector number is the lowest pending line.
- **Externally vectored.** An outside interrupt controller drives a vector number onto the pending field. The mask field is then read as a numeric priority level.

In both vectored modes the offset is the special entry plus the vector number times a programmable spacing.

Top module: `irq_vector_dispatch`

## Requirements
- R1: While reset is held, and on the first cycle after it, `take_irq` is 0 and `vec_off` is 0x0180.
- R2: When `vec_ext_en` is 0, the pending test is true exactly when (`pend_lines` AND `mask_lvl`) is nonzero. This applies to compatibility and internal mode.
- R3: When `vec_ext_en` is 1, the pending test treats both fields as unsigned numbers. It is true only when `pend_lines` is strictly greater than `mask_lvl`.
- R4: `take_irq` is 1 only when the pending test is true, `glob_en` is 1, `exc_lvl` is 0 and `err_lvl` is 0.
- R5: In internal mode (`vec_int_en`=1, `vec_ext_en`=0), the vector number is the index of the lowest set bit of `pend_lines`, counting from bit 0. The mask does not affect this choice. The offset is 0x200 + vector × (`space_fld` × 32).
- R6: In external mode (`vec_ext_en`=1), the vector number is `pend_lines` taken as an unsigned value. The offset is 0x200 + vector × (`space_fld` × 32), truncated to its low 16 bits.
- R7: With both vectored enables at 0, the offset is 0x200 when `spec_vec` is 1 and 0x180 when it is 0.
- R8: With both `vec_int_en` and `vec_ext_en` set, the block behaves exactly as in external mode, for both the pending test and the vector.
- R9: `take_irq` and `vec_off` follow the inputs of the previous clock edge. When `take_irq` is 0, `vec_off` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_lines | input | 8 | Pending interrupt lines, or the external vector number |
| mask_lvl | input | 8 | Per-line mask, or the priority level in external mode |
| glob_en | input | 1 | Global interrupt enable |
| exc_lvl | input | 1 | Exception level active |
| err_lvl | input | 1 | Error level active |
| vec_int_en | input | 1 | Internal vectoring enable |
| vec_ext_en | input | 1 | External controller vectoring enable |
| spec_vec | input | 1 | Special interrupt entry select in compatibility mode |
| space_fld | input | 6 | Vector spacing in units of 32 bytes |
| take_irq | output | 1 | Interrupt is to be taken (registered) |
| vec_off | output | 16 | Handler offset from exception base (registered) |

## Verification
The hardest cases are the ones where the two mask meanings would disagree. One is both vectored enables set, with a pending value equal to the level: the per-line AND would be nonzero, but the strict compare is false. Another is internal mode where the lowest pending line is not an enabled one. The stimulus drives these patterns on purpose. It also sets the widest spacing with vector 255, which checks that the offset wraps to 16 bits. Cycles where the interrupt is not taken follow taken ones, so the bench can see that the offset is held.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    typedef enum logic [1:0] {
        MODE_COMPAT = 2'd0,
        MODE_INTVEC = 2'd1,
        MODE_EXTVEC = 2'd2
    } irq_mode_e;

    // External vectoring wins when both enables are set.
    function automatic irq_mode_e decode_mode(input logic int_en, input logic ext_en);
        if (ext_en)      return MODE_EXTVEC;
        else if (int_en) return MODE_INTVEC;
        else             return MODE_COMPAT;
    endfunction

endpackage

// File: rtl/irq_pend_eval.sv
module irq_pend_eval
    import irq_dispatch_pkg::*;
#(
    parameter int LINES = 8
) (
    input  irq_mode_e          mode,
    input  logic [LINES-1:0]   pend,
    input  logic [LINES-1:0]   mask,
    output logic               pending
);
    logic [LINES-1:0] line_hit;

    // One enable gate per line for the mask interpretation.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign line_hit[g] = pend[g] & mask[g];
    end

    always_comb begin
        if (mode == MODE_EXTVEC) pending = (pend > mask);
        else                     pending = |line_hit;
    end
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select
    import irq_dispatch_pkg::*;
#(
    parameter int LINES = 8
) (
    input  irq_mode_e          mode,
    input  logic [LINES-1:0]   pend,
    output logic [LINES-1:0]   vec_num
);
    logic [LINES-1:0] low_idx;

    // Scan from the top down so the lowest set line is written last.
    always_comb begin
        low_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = LINES'(i);
        end
    end

    always_comb begin
        if (mode == MODE_EXTVEC) vec_num = pend;
        else                     vec_num = low_idx;
    end
endmodule

// File: rtl/irq_off_calc.sv
module irq_off_calc
    import irq_dispatch_pkg::*;
#(
    parameter int          LINES       = 8,
    parameter int          SPACE_W     = 6,
    parameter int          SPACE_SHIFT = 5,
    parameter int          OFF_W       = 16,
    parameter logic [15:0] VEC_BASE    = 16'h0200,
    parameter logic [15:0] GEN_BASE    = 16'h0180
) (
    input  irq_mode_e            mode,
    input  logic [LINES-1:0]     vec_num,
    input  logic [SPACE_W-1:0]   space,
    input  logic                 spec_vec,
    output logic [OFF_W-1:0]     offset
);
    localparam logic [OFF_W-1:0] VEC_OFF = OFF_W'(VEC_BASE);
    localparam logic [OFF_W-1:0] GEN_OFF = OFF_W'(GEN_BASE);

    logic [OFF_W-1:0] stride;
    logic [OFF_W-1:0] scaled;

    always_comb begin
        stride = OFF_W'(space) << SPACE_SHIFT;
        scaled = OFF_W'(vec_num) * stride;
        if (mode == MODE_COMPAT) offset = spec_vec ? VEC_OFF : GEN_OFF;
        else                     offset = VEC_OFF + scaled;
    end
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int SPACE_W     = 6,
    parameter int SPACE_SHIFT = 5,
    parameter int OFF_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINES-1:0]    pend_lines,
    input  logic [LINES-1:0]    mask_lvl,
    input  logic                glob_en,
    input  logic                exc_lvl,
    input  logic                err_lvl,
    input  logic                vec_int_en,
    input  logic                vec_ext_en,
    input  logic                spec_vec,
    input  logic [SPACE_W-1:0]  space_fld,
    output logic                take_irq,
    output logic [OFF_W-1:0]    vec_off
);
    localparam logic [OFF_W-1:0] RST_OFF = OFF_W'(16'h0180);
    localparam logic [OFF_W-1:0] SPC_OFF = OFF_W'(16'h0200);
    localparam logic [OFF_W-1:0] GEN_OFF = OFF_W'(16'h0180);

    typedef struct packed {
        logic             take;
        logic [OFF_W-1:0] off;
    } disp_state_t;

    disp_state_t st_d, st_q;
    irq_mode_e   mode;
    logic        pending;
    logic [LINES-1:0] vec_num;
    logic [OFF_W-1:0] off_calc;

    assign mode = decode_mode(vec_int_en, vec_ext_en);

    irq_pend_eval #(.LINES(LINES)) u_pend (
        .mode    (mode),
        .pend    (pend_lines),
        .mask    (mask_lvl),
        .pending (pending)
    );

    irq_vec_select #(.LINES(LINES)) u_vsel (
        .mode    (mode),
        .pend    (pend_lines),
        .vec_num (vec_num)
    );

    irq_off_calc #(
        .LINES       (LINES),
        .SPACE_W     (SPACE_W),
        .SPACE_SHIFT (SPACE_SHIFT),
        .OFF_W       (OFF_W)
    ) u_off (
        .mode     (mode),
        .vec_num  (vec_num),
        .space    (space_fld),
        .spec_vec (spec_vec),
        .offset   (off_calc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = pending && glob_en && !exc_lvl && !err_lvl;
        if (st_d.take) st_d.off = off_calc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.take <= 1'b0;
            st_q.off  <= RST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_irq = st_q.take;
    assign vec_off  = st_q.off;

    // R4: a take is only raised when the status gating allowed it
    a_r4_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(glob_en && !exc_lvl && !err_lvl));

    // R3: external mode needs a vector strictly above the level
    a_r3_ext_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && $past(vec_ext_en)) |-> $past(pend_lines > mask_lvl));

    // R2: per-line mask modes need an enabled pending line
    a_r2_line_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !$past(vec_ext_en)) |-> $past((pend_lines & mask_lvl) != '0));

    // R7: compatibility mode lands on one of the two fixed entries
    a_r7_compat_off: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && $past(!vec_int_en && !vec_ext_en)) |->
        (vec_off == ($past(spec_vec) ? SPC_OFF : GEN_OFF)));

    // R9: the offset holds while no interrupt is taken
    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (vec_off == $past(vec_off)));

    // R5: internal vector is the lowest pending line
    a_r5_lowest_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INTVEC && pend_lines != '0) |->
        (pend_lines[vec_num[$clog2(LINES)-1:0]] &&
         ((pend_lines & ((LINES'(1) << vec_num[$clog2(LINES)-1:0]) - LINES'(1))) == '0)));
endmodule

// File: tb/irq_vector_dispatch_bench.sv
`timescale 1ns/1ps
module irq_vector_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pend_lines = '0;
    logic [7:0]  mask_lvl = '0;
    logic        glob_en = 1'b0;
    logic        exc_lvl = 1'b0;
    logic        err_lvl = 1'b0;
    logic        vec_int_en = 1'b0;
    logic        vec_ext_en = 1'b0;
    logic        spec_vec = 1'b0;
    logic [5:0]  space_fld = '0;
    logic        take_irq;
    logic [15:0] vec_off;

    typedef struct {
        logic        take;
        logic [15:0] off;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic [15:0] model_off = 16'h0180;
    bit   done = 0;

    always #2 clk = ~clk;

    irq_vector_dispatch u_irq_vector_dispatch (
        .clk(clk), .rst_n(rst_n), .pend_lines(pend_lines), .mask_lvl(mask_lvl),
        .glob_en(glob_en), .exc_lvl(exc_lvl), .err_lvl(err_lvl),
        .vec_int_en(vec_int_en), .vec_ext_en(vec_ext_en), .spec_vec(spec_vec),
        .space_fld(space_fld), .take_irq(take_irq), .vec_off(vec_off)
    );

    task automatic check(input logic t, input logic [15:0] o, input string req);
        n_cmp++;
        if (take_irq !== t || vec_off !== o) begin
            n_bad++;
            $display("FAIL %s: take=%0b off=%h expected take=%0b off=%h",
                     req, take_irq, vec_off, t, o);
        end
    endtask

    // Driver: apply one pattern at the falling edge and queue the expectation.
    task automatic drive(input logic [7:0] p, input logic [7:0] m, input logic ge,
                         input logic el, input logic er, input logic ie,
                         input logic ee, input logic sv, input logic [5:0] sp,
                         input string req);
        exp_t  e;
        logic  pend_ok, t;
        logic [7:0]  vnum;
        logic [15:0] o;
        @(negedge clk);
        pend_lines = p; mask_lvl = m; glob_en = ge; exc_lvl = el; err_lvl = er;
        vec_int_en = ie; vec_ext_en = ee; spec_vec = sv; space_fld = sp;
        pend_ok = ee ? (p > m) : ((p & m) != 0);
        t = pend_ok && ge && !el && !er;
        vnum = 8'd0;
        if (ee) vnum = p;
        else for (int i = 0; i < 8; i++) if (p[i]) begin vnum = 8'(i); break; end
        if (ee || ie) o = 16'h0200 + 16'(32'(vnum) * 32'(sp) * 32);
        else          o = sv ? 16'h0200 : 16'h0180;
        if (t) model_off = o;
        e.take = t; e.off = model_off; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare one cycle after each driven pattern.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.take, e.off, e.req);
            end
        end
    end

    initial begin
        int t_cnt;
        t_cnt = 0;
        while (!done && t_cnt < 20000) begin
            @(posedge clk);
            t_cnt++;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        check(1'b0, 16'h0180, "R1");                         // reset state
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(1'b0, 16'h0180, "R1");                         // first cycle out of reset

        // Compatibility mode: R2, R7, R9
        drive(8'h10, 8'h10, 1, 0, 0, 0, 0, 0, 6'd3, "R7");
        drive(8'h10, 8'h10, 1, 0, 0, 0, 0, 1, 6'd3, "R7");
        drive(8'h10, 8'h0F, 1, 0, 0, 0, 0, 0, 6'd3, "R2");   // masked: holds 0x200
        drive(8'hA5, 8'h04, 1, 0, 0, 0, 0, 0, 6'd0, "R2");
        // Status gating: R4
        drive(8'hFF, 8'hFF, 1, 1, 0, 1, 0, 0, 6'd1, "R4");
        drive(8'hFF, 8'hFF, 1, 0, 1, 1, 0, 0, 6'd1, "R4");
        drive(8'hFF, 8'hFF, 0, 0, 0, 1, 0, 0, 6'd1, "R4");
        // Internal vectoring: R5, R9
        drive(8'h28, 8'h20, 1, 0, 0, 1, 0, 0, 6'd1, "R5");   // lowest line 3 -> 0x260
        drive(8'h80, 8'h80, 1, 0, 0, 1, 0, 0, 6'd2, "R5");   // line 7 -> 0x3C0
        drive(8'h00, 8'hFF, 1, 0, 0, 1, 0, 0, 6'd2, "R9");   // nothing pending: hold
        drive(8'h01, 8'h01, 1, 0, 0, 1, 0, 1, 6'd9, "R5");   // line 0 -> 0x200
        // External vectoring: R3, R6
        drive(8'h05, 8'h05, 1, 0, 0, 0, 1, 0, 6'd4, "R3");   // equal: not taken
        drive(8'h06, 8'h05, 1, 0, 0, 0, 1, 0, 6'd4, "R6");   // 0x500
        drive(8'hFF, 8'h00, 1, 0, 0, 0, 1, 0, 6'd63, "R6");  // wraps to 0xDA20
        drive(8'h04, 8'h80, 1, 0, 0, 0, 1, 0, 6'd1, "R3");   // level above vector
        // Both enables: R8
        drive(8'h03, 8'h01, 1, 0, 0, 1, 1, 0, 6'd1, "R8");   // vector 3 not line 0
        drive(8'h01, 8'h01, 1, 0, 0, 1, 1, 0, 6'd1, "R8");   // strict compare blocks
        // Mixed sweep
        lf = 8'h5B;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            drive(lf, 8'(lf * 8'd7), lf[0] | lf[2], lf[6] & lf[1], 1'b0,
                  lf[3], lf[4] & lf[5], lf[7], 6'(lf ^ 8'h2C), "R9");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule